// File: doc/BRIEF.md
# Byte-Stream Command Mailbox

This block is the device end of a two-register host mailbox. A host with byte-wide access sees a data register at offset 0 and a register at offset 1 that returns a status byte when read and takes a command byte when written. The host opens a transfer with a start command, pushes a command packet one byte at a time, and closes it with an end command. It then polls the status byte and reads the response back through the data register.

The response is framed in-band. First comes a header byte of 0x01 shown together with the framing flag. The payload bytes follow with the flag clear. Last comes a trailer byte of 0x03, again shown with the flag. An abort command can be written at any moment. It drops whatever transfer is in flight and returns the mailbox to the ready-for-command state, so a host that has lost track of the protocol can always recover.

Toward the device, the block offers the received bytes on a take-when-valid port and signals the end of a command and any abort with single-cycle pulses. It draws response bytes from a valid/take port on which the processor marks the last byte. The packets themselves are opaque to the block.

Top module: `mbx_top`

## Requirements
- R1: After reset the status byte reads 0x10 (only ready-for-command, bit 4, set), `cmdValid` is low and `overrun` is low.
- R2: The status byte uses bit 0 for output full, bit 1 for input full, bit 2 for the framing flag, bit 3 for last-write-was-command, bit 4 for ready-for-command and bit 5 for ready-for-data. Writing 0x01 to offset 1 while ready-for-command is set clears bit 4 and sets bit 5, which reads 0x28.
- R3: In the ready-for-data phase, a data write with input full clear stores the byte, sets input full and presents the byte on `cmdValid`/`cmdByte`. Input full clears on the clock edge where `cmdTake` is high.
- R4: A data write made outside the ready-for-data phase, or while input full is set, leaves the held byte and the status unchanged, except for bit 3. It sets the `overrun` output.
- R5: Writing 0x03 to offset 1 in the ready-for-data phase pulses `cmdEnd` for one cycle and clears bit 5. The status then reads 0x08 until a response starts.
- R6: When `respValid` rises after an end command, the data register holds 0x01 while output full and the framing flag are set (status 0x0D). No response byte is taken before the host reads that header.
- R7: Each response byte is taken with `respTake` only while output full is clear. It is shown with output full set and the framing flag clear (status 0x09), in order. A data read clears output full.
- R8: After the byte marked `respLast` has been read, the data register holds 0x03 with status 0x0D. Reading it returns the mailbox to ready-for-command, with status 0x18.
- R9: Bit 3 is set by any write to offset 1 and cleared by any write to offset 0.
- R10: Writing 0x22 to offset 1 in any phase pulses `abortOut`, drops a held input byte, clears `overrun` and leaves the status at 0x19.
- R11: A read of offset 0 while ready-for-command and output full are both set returns the status byte and clears output full.
- R12: Command codes other than 0x01, 0x03 and 0x22, as well as 0x01 outside ready-for-command and 0x03 outside ready-for-data, change nothing except bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 1 | Register select: 0 data, 1 status/command |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWdata | input | DW | Host write byte |
| hostRdata | output | DW | Read data for the selected register |
| cmdValid | output | 1 | A received command byte is waiting |
| cmdByte | output | DW | The waiting command byte |
| cmdTake | input | 1 | Processor accepts the waiting byte |
| cmdEnd | output | 1 | One-cycle pulse on an accepted end command |
| abortOut | output | 1 | One-cycle pulse on an abort command |
| respValid | input | 1 | Processor has a response byte ready |
| respByte | input | DW | Response byte |
| respLast | input | 1 | Current response byte is the final one |
| respTake | output | 1 | Response byte consumed this cycle |
| overrun | output | 1 | Sticky flag for an ignored data write |

## Verification
The assertions assume that the host never raises `hostWr` and `hostRd` in the same cycle. They also assume that `cmdTake` is raised only while `cmdValid` is high, and that `respByte` and `respLast` stay steady while `respValid` is high and no take occurs. The bench drives every host access as a single-cycle strobe from one task. It takes command bytes only after it has seen `cmdValid`, and it advances its response model only on `respTake`, so the stimulus always stays inside those limits. The sweep varies command lengths from 1 to 9 bytes and response lengths from 6 to 14 bytes, and it interleaves aborts in the receive and response phases.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // host command codes
  localparam logic [7:0] CMD_START = 8'h01;
  localparam logic [7:0] CMD_END   = 8'h03;
  localparam logic [7:0] CMD_ABORT = 8'h22;
  // in-band response markers
  localparam logic [7:0] MARK_HDR  = 8'h01;
  localparam logic [7:0] MARK_END  = 8'h03;

  // status bit positions (host software decodes them)
  localparam int SB_OBF = 0;
  localparam int SB_IBF = 1;
  localparam int SB_F0  = 2;
  localparam int SB_A2  = 3;
  localparam int SB_RDY = 4;
  localparam int SB_IBR = 5;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RECV, PH_WAIT, PH_HDR, PH_PAY, PH_END
  } phase_e;

  typedef struct packed {
    logic loadIn;
    logic clrIn;
    logic loadHdr;
    logic loadPay;
    logic loadEnd;
    logic loadCancel;
    logic clrOut;
    logic setA2;
    logic clrA2;
    logic setOvr;
    logic clrOvr;
  } dpStrb_t;
endpackage

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrb_t       strb,
  input  logic [DW-1:0] hostWdata,
  input  logic [DW-1:0] respByte,
  input  logic          cmdTake,
  output logic          ibf,
  output logic          obf,
  output logic          f0,
  output logic          a2,
  output logic          ovr,
  output logic [DW-1:0] inByte,
  output logic [DW-1:0] outByte
);

  // inbound holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ibf    <= 1'b0;
      inByte <= '0;
    end else if (strb.clrIn) begin
      ibf <= 1'b0;
    end else if (strb.loadIn) begin
      ibf    <= 1'b1;
      inByte <= hostWdata;
    end else if (cmdTake) begin
      ibf <= 1'b0;
    end
  end

  // outbound register with framing flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      obf     <= 1'b0;
      f0      <= 1'b0;
      outByte <= '0;
    end else if (strb.loadCancel) begin
      obf <= 1'b1;
      f0  <= 1'b0;
    end else if (strb.loadHdr) begin
      obf     <= 1'b1;
      f0      <= 1'b1;
      outByte <= DW'(MARK_HDR);
    end else if (strb.loadPay) begin
      obf     <= 1'b1;
      f0      <= 1'b0;
      outByte <= respByte;
    end else if (strb.loadEnd) begin
      obf     <= 1'b1;
      f0      <= 1'b1;
      outByte <= DW'(MARK_END);
    end else if (strb.clrOut) begin
      obf <= 1'b0;
      f0  <= 1'b0;
    end
  end

  // last-write-was-command flag and sticky overrun
  always_ff @(posedge clk) begin
    if (!rstN) begin
      a2  <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (strb.setA2)      a2 <= 1'b1;
      else if (strb.clrA2) a2 <= 1'b0;
      if (strb.clrOvr)      ovr <= 1'b0;
      else if (strb.setOvr) ovr <= 1'b1;
    end
  end

  AST_F0_NEEDS_OBF: assert property (@(posedge clk) disable iff (!rstN)
    f0 |-> obf); // R6

  AST_IBF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ibf && !cmdTake && !strb.clrIn) |=> ibf); // R3

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostAddr,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] cmdCode,
  input  logic       ibf,
  input  logic       obf,
  input  logic       respValid,
  input  logic       respLast,
  output dpStrb_t    strb,
  output logic       cmdEnd,
  output logic       abortOut,
  output logic       respTake,
  output logic       rdy,
  output logic       ibr
);

  phase_e phase, phaseNext;
  logic   lastSeen, lastSeenNext;
  logic   cmdWr, dataWr, dataRd;

  assign cmdWr  = hostWr && hostAddr;
  assign dataWr = hostWr && !hostAddr;
  assign dataRd = hostRd && !hostAddr;
  assign rdy    = (phase == PH_IDLE);
  assign ibr    = (phase == PH_RECV);

  always_comb begin
    strb         = '0;
    cmdEnd       = 1'b0;
    abortOut     = 1'b0;
    respTake     = 1'b0;
    phaseNext    = phase;
    lastSeenNext = lastSeen;

    if (cmdWr) strb.setA2 = 1'b1;
    if (dataWr) begin
      strb.clrA2 = 1'b1;
      if (phase == PH_RECV && !ibf) strb.loadIn = 1'b1;
      else                          strb.setOvr = 1'b1;
    end
    if (dataRd && obf) strb.clrOut = 1'b1;

    if (cmdWr && cmdCode == CMD_ABORT) begin
      strb.clrIn      = 1'b1;
      strb.loadCancel = 1'b1;
      strb.clrOvr     = 1'b1;
      strb.setOvr     = 1'b0;
      abortOut        = 1'b1;
      lastSeenNext    = 1'b0;
      phaseNext       = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: if (cmdWr && cmdCode == CMD_START) begin
          strb.clrOut = 1'b1;
          phaseNext   = PH_RECV;
        end
        PH_RECV: if (cmdWr && cmdCode == CMD_END) begin
          cmdEnd    = 1'b1;
          phaseNext = PH_WAIT;
        end
        PH_WAIT: if (respValid) begin
          strb.loadHdr = 1'b1;
          lastSeenNext = 1'b0;
          phaseNext    = PH_HDR;
        end
        PH_HDR, PH_PAY: if (!obf) begin
          if (phase == PH_PAY && lastSeen) begin
            strb.loadEnd = 1'b1;
            phaseNext    = PH_END;
          end else if (respValid) begin
            strb.loadPay = 1'b1;
            respTake     = 1'b1;
            lastSeenNext = respLast;
            phaseNext    = PH_PAY;
          end
        end
        PH_END: if (!obf) phaseNext = PH_IDLE;
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      lastSeen <= 1'b0;
    end else begin
      phase    <= phaseNext;
      lastSeen <= lastSeenNext;
    end
  end

  AST_END_DROPS_IBR: assert property (@(posedge clk) disable iff (!rstN)
    cmdEnd |=> !ibr && !rdy); // R5

endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostAddr,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic [DW-1:0] hostWdata,
  output logic [DW-1:0] hostRdata,
  output logic          cmdValid,
  output logic [DW-1:0] cmdByte,
  input  logic          cmdTake,
  output logic          cmdEnd,
  output logic          abortOut,
  input  logic          respValid,
  input  logic [DW-1:0] respByte,
  input  logic          respLast,
  output logic          respTake,
  output logic          overrun
);

  dpStrb_t       strb;
  logic          ibf, obf, f0, a2, rdy, ibr;
  logic [DW-1:0] outByte;
  logic [7:0]    statBits;
  logic [DW-1:0] statusByte;

  mbx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .cmdCode(hostWdata[7:0]),
    .ibf(ibf), .obf(obf),
    .respValid(respValid), .respLast(respLast),
    .strb(strb), .cmdEnd(cmdEnd), .abortOut(abortOut),
    .respTake(respTake), .rdy(rdy), .ibr(ibr)
  );

  mbx_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostWdata(hostWdata), .respByte(respByte), .cmdTake(cmdTake),
    .ibf(ibf), .obf(obf), .f0(f0), .a2(a2), .ovr(overrun),
    .inByte(cmdByte), .outByte(outByte)
  );

  always_comb begin
    statBits         = '0;
    statBits[SB_OBF] = obf;
    statBits[SB_IBF] = ibf;
    statBits[SB_F0]  = f0;
    statBits[SB_A2]  = a2;
    statBits[SB_RDY] = rdy;
    statBits[SB_IBR] = ibr;
  end

  assign statusByte = DW'(statBits);
  assign cmdValid   = ibf;
  // a data poll while ready with output full returns the status copy
  assign hostRdata  = (hostAddr || (rdy && obf)) ? statusByte : outByte;

  AST_START_OPENS_RECV: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr && hostWdata[7:0] == CMD_START && statBits[SB_RDY])
      |=> statBits[SB_IBR] && !statBits[SB_RDY]); // R2

  AST_CANCEL_READY: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr && hostWdata[7:0] == CMD_ABORT)
      |=> statBits == 8'h19 && !cmdValid && !overrun); // R10

  AST_TAKE_LOADS_OUT: assert property (@(posedge clk) disable iff (!rstN)
    respTake |=> statBits[SB_OBF] && !statBits[SB_F0]); // R7

  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostAddr && cmdValid && !cmdTake)
      |=> cmdValid && $stable(cmdByte)); // R4

endmodule

// File: tb/sim_mbx_top.sv
module sim_mbx_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostAddr = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [DW-1:0] hostWdata = '0;
  logic [DW-1:0] hostRdata;
  logic          cmdValid, cmdEnd, abortOut, respTake, overrun;
  logic [DW-1:0] cmdByte;
  logic          cmdTake = 1'b0;
  logic          respValid, respLast;
  logic [DW-1:0] respByte;

  int checks = 0, fails = 0;
  int endCnt = 0, abortCnt = 0;
  bit finished = 0;

  // response model
  logic [7:0] respMem [0:31];
  int         respLen = 0;
  int         respIdx = 0;
  logic       respArmed = 1'b0;
  logic       respRestart = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (respRestart)   respIdx <= 0;
    else if (respTake) respIdx <= respIdx + 1;
    if (cmdEnd)   endCnt   <= endCnt + 1;
    if (abortOut) abortCnt <= abortCnt + 1;
  end

  assign respValid = respArmed && (respIdx < respLen);
  assign respByte  = respMem[respIdx[4:0]];
  assign respLast  = (respIdx == respLen - 1);

  mbx_top #(.DW(DW)) u0 (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .cmdTake(cmdTake),
    .cmdEnd(cmdEnd), .abortOut(abortOut),
    .respValid(respValid), .respByte(respByte), .respLast(respLast),
    .respTake(respTake), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic rdReg(input logic a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic takeCmd();
    @(negedge clk); cmdTake = 1'b1;
    @(negedge clk); cmdTake = 1'b0;
  endtask

  task automatic pollFor(input int bitPos, output logic [7:0] s);
    for (int k = 0; k < 40; k++) begin
      rdReg(1'b1, s);
      if (s[bitPos]) break;
    end
  endtask

  task automatic armResp(input int rl, input int tag);
    respMem[0] = 8'hC4;
    respMem[1] = 8'(tag);
    respMem[2] = 8'(rl >> 24);
    respMem[3] = 8'(rl >> 16);
    respMem[4] = 8'(rl >> 8);
    respMem[5] = 8'(rl);
    for (int i = 6; i < 32; i++) respMem[i] = 8'((i * 29 + rl) & 8'hFF);
    respLen = rl;
    @(negedge clk); respRestart = 1'b1;
    @(negedge clk); respRestart = 1'b0; respArmed = 1'b1;
  endtask

  task automatic doTxn(input int cl, input int rl);
    logic [7:0] s, d, b;
    logic [7:0] got [0:31];
    int e0, lenField;
    wrReg(1'b1, 8'h01);
    rdReg(1'b1, s); chk("R2 start status", s, 8'h28);
    for (int i = 0; i < cl; i++) begin
      b = 8'((cl * 37 + i * 11) & 8'hFF);
      wrReg(1'b0, b);
      rdReg(1'b1, s); chk("R3 ibf set", s, 8'h22);
      chk("R3 cmdValid", int'(cmdValid), 1);
      chk("R3 cmdByte", cmdByte, b);
      takeCmd();
      rdReg(1'b1, s); chk("R3 ibf clear", s, 8'h20);
    end
    e0 = endCnt;
    wrReg(1'b1, 8'h03);
    chk("R5 cmdEnd pulses", endCnt, e0 + 1);
    rdReg(1'b1, s); chk("R5 wait status", s, 8'h08);
    armResp(rl, cl);
    pollFor(2, s); chk("R6 header status", s, 8'h0D);
    chk("R6 nothing taken", respIdx, 0);
    rdReg(1'b0, d); chk("R6 header byte", d, 8'h01);
    for (int i = 0; i < rl; i++) begin
      pollFor(0, s); chk("R7 payload status", s, 8'h09);
      rdReg(1'b0, d); chk("R7 payload byte", d, respMem[i]);
      got[i] = d;
    end
    lenField = {got[2], got[3], got[4], got[5]};
    chk("R7 length field", lenField, rl);
    pollFor(0, s); chk("R8 trailer status", s, 8'h0D);
    rdReg(1'b0, d); chk("R8 trailer byte", d, 8'h03);
    rdReg(1'b1, s); chk("R8 back to ready", s, 8'h18);
    chk("R7 all taken", respIdx, rl);
    respArmed = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    int e0, a0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rdReg(1'b1, s); chk("R1 reset status", s, 8'h10);
    chk("R1 cmdValid", int'(cmdValid), 0);
    chk("R1 overrun", int'(overrun), 0);

    // out-of-phase and unknown codes in idle
    e0 = endCnt;
    wrReg(1'b1, 8'h55);
    rdReg(1'b1, s); chk("R9 A2 set", s, 8'h18);
    wrReg(1'b1, 8'h03);
    rdReg(1'b1, s); chk("R12 end in idle", s, 8'h18);
    chk("R12 no cmdEnd", endCnt, e0);
    wrReg(1'b0, 8'h77);
    rdReg(1'b1, s); chk("R9 A2 cleared", s, 8'h10);
    chk("R4 overrun idle", int'(overrun), 1);
    chk("R4 no cmdValid", int'(cmdValid), 0);

    // abort from idle, status copy
    a0 = abortCnt;
    wrReg(1'b1, 8'h22);
    rdReg(1'b1, s); chk("R10 cancel status", s, 8'h19);
    chk("R10 abort pulse", abortCnt, a0 + 1);
    chk("R10 overrun cleared", int'(overrun), 0);
    rdReg(1'b0, d); chk("R11 status copy", d, 8'h19);
    rdReg(1'b1, s); chk("R11 obf cleared", s, 8'h18);

    // overrun while input full, bad codes in receive phase
    wrReg(1'b1, 8'h01);
    wrReg(1'b0, 8'hA1);
    wrReg(1'b0, 8'hB2);
    chk("R4 byte kept", cmdByte, 8'hA1);
    chk("R4 overrun recv", int'(overrun), 1);
    rdReg(1'b1, s); chk("R4 status", s, 8'h22);
    wrReg(1'b1, 8'h01);
    rdReg(1'b1, s); chk("R12 start in recv", s, 8'h2A);
    wrReg(1'b1, 8'h99);
    rdReg(1'b1, s); chk("R12 unknown code", s, 8'h2A);
    wrReg(1'b1, 8'h22);
    rdReg(1'b1, s); chk("R10 cancel recv", s, 8'h19);
    chk("R10 input dropped", int'(cmdValid), 0);

    // abort in the middle of a response
    wrReg(1'b1, 8'h01);
    wrReg(1'b0, 8'h5A);
    takeCmd();
    wrReg(1'b1, 8'h03);
    armResp(8, 1);
    pollFor(2, s);
    rdReg(1'b0, d); chk("R6 header mid", d, 8'h01);
    pollFor(0, s);
    rdReg(1'b0, d); chk("R7 first byte", d, 8'hC4);
    wrReg(1'b1, 8'h22);
    respArmed = 1'b0;
    rdReg(1'b1, s); chk("R10 cancel resp", s, 8'h19);
    rdReg(1'b0, d); chk("R11 copy after resp", d, 8'h19);
    rdReg(1'b1, s); chk("R11 ready again", s, 8'h18);

    // sweep of command and response lengths
    for (int t = 0; t < 9; t++) doTxn(t + 1, 6 + t);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule